// File: doc/BRIEF.md
# Dual-Source Trace Line Packer

This block records program-flow and data-access events from two independent bus masters, a main CPU and a coprocessor, into 64-bit lines of an on-chip trace RAM. Each event becomes a 4-byte slot: an info byte on top, then the address bytes from most to least significant. The packer presents one RAM write per finished line, a running entry counter and a sticky flag that shows the RAM has wrapped.

There are four capture modes. In the two single-source modes, two change-of-flow entries from the selected master share one line. The counter's lowest bit then tells whether a half line is pending. In the both-sources mode, any change of flow writes a line with the CPU slot in the upper half and the coprocessor slot in the lower half. The half of an idle source is all zero, so its valid bit reads 0. In detail mode, each data access becomes one line that carries its address and data bytes. Software sets the mode while capture is off. Lowering the enable ends a run and flushes any half line.

Top module: `trace_line_packer`

## Requirements
- R1: After reset, or in the cycle after `clr` is sampled high, `entry_cnt` is 0, `wrapped` is 0 and `ram_we` is 0. Any pending half line is discarded.
- R2: In modes 0 (CPU only) and 1 (coprocessor only), each change of flow from the selected source adds 1 to `entry_cnt`. The first entry of a pair writes nothing and leaves bit 0 of the counter at 1. The second entry writes the line with the new slot in bits 63:32 and the held slot in bits 31:0.
- R3: A CPU slot is {1'b1, cpu_flags[6:0], cpu_addr[23:0]}. A coprocessor slot is {1'b1, cop_flags[6:0], 8'h00, cop_addr[15:0]}. Bit 7 of each info byte is the slot's valid flag.
- R4: In a single-source mode, strobes from the other source do not change the counter and do not write the RAM.
- R5: In mode 2 (both), a cycle with any change of flow writes one line. The CPU slot goes in bits 63:32 and the coprocessor slot in bits 31:0. The half of a source without an event is 32'h0. `entry_cnt` advances by 2.
- R6: In mode 3 (detail), each `acc_vld` writes one line {info, acc_addr[23:0], d3, d2, 16'h0}, with info = {1'b1, acc_wr, acc_word, 5'b0}, and `entry_cnt` advances by 2. For a word access, d3 is `acc_data[15:8]` (the lower-address byte) and d2 is `acc_data[7:0]`. For a byte access, d3 is 0 and d2 is `acc_data[7:0]`.
- R7: In the first cycle `en` is low while a half line is pending, the line {32'h0, held slot} is written and `entry_cnt` advances by 1.
- R8: While `en` is low, no strobe is captured, and no write occurs other than the flush of R7.
- R9: `wrapped` rises when a line is written to address DEPTH-1. It then stays high until `clr` or reset, while the write address wraps to 0.
- R10: Each line is written with a single-cycle `ram_we` pulse, one cycle after the capturing edge. `ram_addr` is the line index, and after each write `entry_cnt[AW:1]` equals `ram_addr`+1 modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counter, pointer and wrap flag |
| en | input | 1 | Capture enable; falling edge flushes a half line |
| mode | input | 2 | 0 CPU, 1 coprocessor, 2 both, 3 detail |
| cpu_cof | input | 1 | CPU change-of-flow strobe |
| cpu_addr | input | 24 | CPU event address |
| cpu_flags | input | 7 | CPU info flags (read/write, source/destination) |
| cop_cof | input | 1 | Coprocessor change-of-flow strobe |
| cop_addr | input | 16 | Coprocessor event address |
| cop_flags | input | 7 | Coprocessor info flags |
| acc_vld | input | 1 | Data access strobe (detail mode) |
| acc_wr | input | 1 | Access is a write |
| acc_word | input | 1 | Access is a 16-bit word |
| acc_addr | input | 24 | Access address |
| acc_data | input | 16 | Access data, [15:8] from the lower address |
| ram_we | output | 1 | Trace RAM write strobe |
| ram_addr | output | AW | Trace RAM line address |
| ram_wdata | output | 64 | Trace RAM line data |
| entry_cnt | output | AW+1 | Entry counter, bit 0 marks a pending half line |
| wrapped | output | 1 | Sticky wrap flag |

## Verification
The bench builds the packer with DEPTH set to 8. With that depth, the write pointer passes the last address many times within a short random run, so the wrap flag, its stickiness and its clearing are all exercised, as is counter rollover while a half line is pending. The default of 64 lines stays in the RTL elaboration and in the bound checker. With a depth of 8, random epochs in every mode can end with a flush in almost any pointer state.

// File: rtl/trace_line_packer.sv
module trace_line_packer #(
  parameter int DEPTH = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              en,
  input  logic [1:0]                        mode,
  input  logic                              cpu_cof,
  input  logic [23:0]                       cpu_addr,
  input  logic [6:0]                        cpu_flags,
  input  logic                              cop_cof,
  input  logic [15:0]                       cop_addr,
  input  logic [6:0]                        cop_flags,
  input  logic                              acc_vld,
  input  logic                              acc_wr,
  input  logic                              acc_word,
  input  logic [23:0]                       acc_addr,
  input  logic [15:0]                       acc_data,
  output logic                              ram_we,
  output logic [$clog2(DEPTH)-1:0]          ram_addr,
  output logic [63:0]                       ram_wdata,
  output logic [$clog2(DEPTH):0]            entry_cnt,
  output logic                              wrapped
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   ONE  = 1;
  localparam logic [AW:0]   TWO  = 2;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW:0]  cnt;
  logic         half;
  logic [31:0]  held;
  logic         wr_now;
  logic [63:0]  line_n;
  logic [AW:0]  step;

  wire [31:0] cpu_slot  = {1'b1, cpu_flags, cpu_addr};
  wire [31:0] cop_slot  = {1'b1, cop_flags, 8'h00, cop_addr};
  wire [7:0]  acc_info  = {1'b1, acc_wr, acc_word, 5'b0};
  wire [15:0] acc_bytes = acc_word ? acc_data : {8'h00, acc_data[7:0]};
  wire [63:0] det_line  = {acc_info, acc_addr, acc_bytes, 16'h0000};
  wire [63:0] both_line = {cpu_cof ? cpu_slot : 32'h0, cop_cof ? cop_slot : 32'h0};

  wire        single = !mode[1];
  wire        s_cof  = mode[0] ? cop_cof : cpu_cof;
  wire [31:0] s_slot = mode[0] ? cop_slot : cpu_slot;
  wire        s_hit  = en && single && s_cof;
  wire [AW-1:0] line_idx = cnt[AW:1];

  always_comb begin
    wr_now = 1'b0;
    line_n = 64'h0;
    step   = '0;
    if (en) begin
      if (single) begin
        if (s_cof) begin
          step = ONE;
          if (half) begin
            wr_now = 1'b1;
            line_n = {s_slot, held};
          end
        end
      end else if (!mode[0]) begin
        if (cpu_cof || cop_cof) begin
          wr_now = 1'b1;
          line_n = both_line;
          step   = TWO;
        end
      end else if (acc_vld) begin
        wr_now = 1'b1;
        line_n = det_line;
        step   = TWO;
      end
    end else if (half) begin
      wr_now = 1'b1;
      line_n = {32'h0, held};
      step   = ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      half      <= 1'b0;
      held      <= 32'h0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= 64'h0;
      wrapped   <= 1'b0;
    end else if (clr) begin
      cnt       <= '0;
      half      <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      wrapped   <= 1'b0;
    end else begin
      cnt    <= cnt + step;
      ram_we <= wr_now;
      if (wr_now) begin
        ram_addr  <= line_idx;
        ram_wdata <= line_n;
        if (line_idx == LAST) wrapped <= 1'b1;
      end
      if (s_hit) begin
        half <= !half;
        if (!half) held <= s_slot;
      end else if (!en) begin
        half <= 1'b0;
      end
    end
  end

  assign entry_cnt = cnt;
endmodule

// File: rtl/trace_line_packer_chk.sv
module trace_line_packer_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       en,
  input logic [1:0]                 mode,
  input logic                       ram_we,
  input logic [$clog2(DEPTH)-1:0]   ram_addr,
  input logic [63:0]                ram_wdata,
  input logic [$clog2(DEPTH):0]     entry_cnt,
  input logic                       wrapped
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (entry_cnt == '0 && !wrapped && !ram_we));

  // R10
  line_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (entry_cnt[AW:1] == ram_addr + 1'b1) && !entry_cnt[0]);

  // R9
  wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped && !clr |=> wrapped);

  // R9
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && ram_addr == LAST |-> wrapped);

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(en) || $past(en, 2)));

  // R2
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(en) && !$past(mode[1]) |-> ram_wdata[63] && ram_wdata[31]);

  // R5
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(en) && $past(mode) == 2'd2 |-> ram_wdata[63] || ram_wdata[31]);

  // R6
  detail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(en) && $past(mode) == 2'd3 |-> ram_wdata[63] && ram_wdata[15:0] == 16'h0);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !$past(en) |-> ram_wdata[63:32] == 32'h0 && ram_wdata[31]);
endmodule

bind trace_line_packer trace_line_packer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .mode(mode),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .entry_cnt(entry_cnt), .wrapped(wrapped)
);

// File: tb/trace_line_packer_test.sv
`timescale 1ns/1ps
module trace_line_packer_test;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, clr = 0, en = 0;
  logic [1:0] mode = 0;
  logic cpu_cof = 0, cop_cof = 0, acc_vld = 0, acc_wr = 0, acc_word = 0;
  logic [23:0] cpu_addr = 0, acc_addr = 0;
  logic [15:0] cop_addr = 0, acc_data = 0;
  logic [6:0] cpu_flags = 0, cop_flags = 0;
  logic ram_we, wrapped;
  logic [AW-1:0] ram_addr;
  logic [63:0] ram_wdata;
  logic [AW:0] entry_cnt;

  int nchk = 0, nerr = 0;
  int m_cnt = 0;
  bit m_half = 0, m_wrap = 0;
  logic [31:0] m_held = 0;

  always #2.5 clk = ~clk;

  trace_line_packer #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL R10: watchdog expired, actual hang expected completion");
    finish_run();
  end

  task automatic clear_inputs();
    cpu_cof = 0; cop_cof = 0; acc_vld = 0; clr = 0;
  endtask

  // one clock: model from requirements, edge, compare, back to negedge
  task automatic cyc(string tag);
    logic [31:0] cs, ps, slot;
    logic [63:0] e_data;
    bit e_we, hit;
    int wa;
    cs = {1'b1, cpu_flags, cpu_addr};
    ps = {1'b1, cop_flags, 8'h00, cop_addr};
    e_we = 0; e_data = 0; wa = (m_cnt / 2) % DEPTH;
    if (clr) begin
      m_cnt = 0; m_wrap = 0; m_half = 0;
    end else begin
      if (en) begin
        if (mode < 2) begin
          hit  = (mode == 0) ? cpu_cof : cop_cof;
          slot = (mode == 0) ? cs : ps;
          if (hit) begin
            if (m_half) begin e_we = 1; e_data = {slot, m_held}; m_half = 0; end
            else begin m_held = slot; m_half = 1; end
            m_cnt++;
          end
        end else if (mode == 2) begin
          if (cpu_cof || cop_cof) begin
            e_we = 1;
            e_data = {cpu_cof ? cs : 32'h0, cop_cof ? ps : 32'h0};
            m_cnt += 2;
          end
        end else if (acc_vld) begin
          e_we = 1;
          e_data = {1'b1, acc_wr, acc_word, 5'b0, acc_addr,
                    acc_word ? acc_data[15:8] : 8'h00, acc_data[7:0], 16'h0};
          m_cnt += 2;
        end
      end else if (m_half) begin
        e_we = 1; e_data = {32'h0, m_held}; m_half = 0; m_cnt++;
      end
      if (e_we && wa == DEPTH - 1) m_wrap = 1;
      m_cnt = m_cnt % (2 * DEPTH);
    end
    @(posedge clk); #1;
    chk("R10 we", 64'(ram_we), 64'(e_we));
    if (e_we) begin
      chk("R10 addr", 64'(ram_addr), 64'(wa));
      chk(tag, ram_wdata, e_data);
    end
    chk("R2 cnt", 64'(entry_cnt), 64'(m_cnt));
    chk("R9 wrap", 64'(wrapped), 64'(m_wrap));
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R1 reset cnt", 64'(entry_cnt), 0);
    chk("R1 reset wrap", 64'(wrapped), 0);
    chk("R1 reset we", 64'(ram_we), 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: CPU pair
    mode = 0; en = 1;
    cpu_cof = 1; cpu_addr = 24'h123456; cpu_flags = 7'h15; cyc("R2 first");
    chk("R2 half bit", 64'(entry_cnt[0]), 1);
    cpu_cof = 1; cpu_addr = 24'hABCDEF; cpu_flags = 7'h2A; cyc("R3 cpu pair");
    chk("R3 cpu line", ram_wdata, 64'hAABCDEF_95123456 | 64'hA000_0000_0000_0000);
    // R4: coprocessor ignored in CPU mode
    cop_cof = 1; cop_addr = 16'h1111; cyc("R4 ignored");
    chk("R4 no write", 64'(ram_we), 0);
    // R3 coprocessor slot and R7 flush
    en = 0; cyc("R7 idle");
    mode = 1; en = 1;
    cop_cof = 1; cop_addr = 16'hBEEF; cop_flags = 7'h01; cyc("R3 cop first");
    en = 0; cyc("R7 flush");
    chk("R7 flush line", ram_wdata, 64'h00000000_8100BEEF);
    // R8: strobes while disabled
    cpu_cof = 1; cop_cof = 1; acc_vld = 1; cyc("R8 disabled");
    chk("R8 no write", 64'(ram_we), 0);
    // R5: both sources
    mode = 2; en = 1;
    cpu_cof = 1; cop_cof = 1; cpu_addr = 24'h010203; cpu_flags = 0;
    cop_addr = 16'h0405; cop_flags = 0; cyc("R5 both");
    chk("R5 both line", ram_wdata, 64'h80010203_80000405);
    cop_cof = 1; cyc("R5 cop only");
    chk("R5 idle cpu half", 64'(ram_wdata[63:32]), 0);
    // R6: detail byte and word
    mode = 3;
    acc_vld = 1; acc_wr = 1; acc_word = 0; acc_addr = 24'h00A0B0; acc_data = 16'h7788;
    cyc("R6 byte");
    chk("R6 byte line", ram_wdata, 64'hC000A0B0_0088_0000);
    acc_vld = 1; acc_wr = 0; acc_word = 1; cyc("R6 word");
    chk("R6 word line", ram_wdata, 64'hA000A0B0_7788_0000);
    // R9: run past the last address
    mode = 2;
    for (int i = 0; i < DEPTH; i++) begin cpu_cof = 1; cyc("R9 fill"); end
    chk("R9 wrapped set", 64'(wrapped), 1);
    en = 0; cyc("R9 idle");
    chk("R9 still set", 64'(wrapped), 1);
    // R1: clear
    clr = 1; cyc("R1 clear");
    chk("R1 clr cnt", 64'(entry_cnt), 0);

    // random epochs
    for (int ep = 0; ep < 80; ep++) begin
      string tg;
      en = 0;
      if ($urandom % 8 == 0) clr = 1;
      cyc("R7 epoch end");
      mode = 2'($urandom % 4);
      tg = (mode < 2) ? "R2 rand" : (mode == 2) ? "R5 rand" : "R6 rand";
      en = 1;
      for (int k = 0; k < int'($urandom_range(3, 30)); k++) begin
        cpu_cof = ($urandom % 3 == 0); cop_cof = ($urandom % 3 == 0);
        acc_vld = ($urandom % 3 == 0);
        cpu_addr = 24'($urandom); cpu_flags = 7'($urandom);
        cop_addr = 16'($urandom); cop_flags = 7'($urandom);
        acc_addr = 24'($urandom); acc_data = 16'($urandom);
        acc_wr = 1'($urandom); acc_word = 1'($urandom);
        cyc(tg);
      end
      en = 0; cpu_cof = 1'($urandom); cop_cof = 1'($urandom); acc_vld = 1;
      cyc("R8 rand");
    end
    finish_run();
  end
endmodule